// File: doc/BRIEF.md
# SPI Register-Access Target with Even Parity

This block is the target side of a four-wire serial link that lets an external controller read and write a small bank of 16-bit registers. The controller lowers the select line, clocks in an 8-bit header (direction flag, 6-bit register address, header parity bit) and then any number of 16-bit data words. While the header arrives, the block returns a status byte. During every later word it returns the register addressed by its read pointer. A read pointer and a write pointer are kept apart and both advance by themselves, so a long burst walks through consecutive registers. A header-only read frame moves the read pointer alone. A following write burst can then watch one group of registers while it writes another.

Optional even-parity protection covers the header and every written word. A parity failure blocks the write and poisons the rest of the burst. It also raises a sticky flag that pulls an active-low fault output. A frame that ends in the middle of a word raises a second sticky flag. Both flags stay set until a clear pulse. The serial pins are oversampled by the system clock. SCLK must therefore stay in each level for at least three system clock cycles.

Top module: `spi_rg_target`

## Requirements
- R1: A header with bit 7 = 1 is a read. Its bits 6..1 load the read pointer. Each following 16-bit word returns the register at the read pointer, and the pointer then advances by one, wrapping from 63 to 0.
- R2: During the 8 header clocks SDO returns the byte {status_in[5:0], parity flag, frame flag}, MSB first, captured when select falls.
- R3: SDI is captured on SCLK falling edges and SDO changes only after SCLK rising edges (or the select falling edge), MSB first.
- R4: While csn is high, sdo_oe is 0 and SCLK/SDI activity writes no register and moves no pointer.
- R5: A header with bit 7 = 0 is a write. Its address loads the write pointer and the read pointer keeps its value. Each completed word is written at the write pointer, and then both pointers advance. SDO meanwhile carries the register at the read pointer.
- R6: With parity off, written words are stored as all 16 bits received. With parity on, bit 15 is the word's parity bit and is stored as 0, with bits 14..0 stored as received.
- R7: With parity on, a written word whose 16 bits hold an odd count of ones is not stored. No later word of that burst is stored, the write pointer stays put, and the parity flag is set.
- R8: With parity on, a header with an odd count of ones sets the parity flag. A read still returns register data. A write stores nothing for the whole burst and leaves the write pointer unchanged.
- R9: With parity on, bit 15 of each returned word is replaced by the XOR of bits 14..0.
- R10: A frame that ends after a partial header or a partial data word sets the frame flag, and the partial word is not stored. A frame of exactly 8 header bits is valid.
- R11: After reset both flags are clear and fault_n is 1. A set flag stays set until clr_fault is 1 for a clock. fault_n is 0 whenever either flag is set.
- R12: With parity off, parity bits in header and data are not checked and never set the parity flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| csn | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from controller |
| sdo | output | 1 | Serial data to controller |
| sdo_oe | output | 1 | Output enable for the SDO driver |
| par_en | input | 1 | Enables parity checking and read-parity insertion |
| clr_fault | input | 1 | Clears both sticky flags |
| status_in | input | 6 | Upper six bits of the returned status byte |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 6 | Register write address |
| reg_wr_data | output | 16 | Register write data |
| reg_rd_addr | output | 6 | Register read address (read pointer) |
| reg_rd_data | input | 16 | Register contents at reg_rd_addr, combinational |
| fault_n | output | 1 | Active-low fault, either flag set |

## Verification
Read and write bursts are run with parity off and with parity on. Each returned word is compared against a bench model of the register bank and of both pointers. A write that begins at a pointer left behind by a read shows that the two pointers are independent. A read that crosses address 63 shows the wrap. Within one parity-on write burst, good, corrupted and again good words show that one bad word poisons the rest of the burst. Header-parity errors are tried on a read and on a write, to show that data still flows on the read but no write lands. Truncated headers and truncated words are set against an exact header-only frame, and noise with select high is set against a normal frame, so that the frame flag and the idle state are told apart.

// File: rtl/spi_rg_pkg.sv
// Shared definitions for the SPI register-access target.
// Assumes: data words are at least as wide as the header.
package spi_rg_pkg;
    localparam int DEF_ADDR_W = 6;
    localparam int DEF_DATA_W = 16;

    // Sticky error state reported on the fault pin and in the status byte.
    typedef struct packed {
        logic parity;
        logic frame;
    } fault_t;
endpackage

// File: rtl/spi_rg_edge.sv
// Oversampling edge detector for the select and serial clock pins.
// Assumes csn and sclk are held for at least three clk cycles per level.
// Serial-clock edges are reported only while the frame is selected.
module spi_rg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_fall,
    output logic sck_rise
);
    logic csn_q;
    logic sclk_q;

    // Keep the previous pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csn_q  <= csn;
            sclk_q <= sclk;
        end
    end

    // Decode edges; serial clock edges are gated by an active select.
    always_comb begin
        cs_fall  = csn_q & ~csn;
        cs_rise  = ~csn_q & csn;
        sck_fall = ~csn & ~csn_q & sclk_q & ~sclk;
        sck_rise = ~csn & ~csn_q & ~sclk_q & sclk;
    end
endmodule

// File: rtl/spi_rg_rx.sv
// Receive path: header and word framing, parity checks, read/write
// pointers, write strobe and the sticky fault flags.
// Assumes edge pulses come from spi_rg_edge, one clk cycle each.
module spi_rg_rx
    import spi_rg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic              par_en,
    input  logic              clr_fault,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              word_ready,
    output fault_t            flags
);
    localparam int HDR_W  = ADDR_W + 2;
    localparam int HCNT_W = $clog2(HDR_W);
    localparam int WCNT_W = $clog2(DATA_W);

    logic [DATA_W-2:0] rx_sh;
    logic [HCNT_W-1:0] hcnt;
    logic [WCNT_W-1:0] wcnt;
    logic              hdr_done;
    logic              is_read;
    logic              burst_bad;
    logic [ADDR_W-1:0] wr_ptr;

    logic [DATA_W-1:0] next_bits;
    logic [HDR_W-1:0]  hdr;
    logic              hdr_ok;
    logic              word_ok;
    logic              hdr_end;
    logic              word_end;
    logic              partial;

    // Decode the bit arriving now together with the bits already held.
    always_comb begin
        next_bits = {rx_sh, sdi};
        hdr       = next_bits[HDR_W-1:0];
        hdr_ok    = !par_en || !(^hdr);
        word_ok   = !par_en || !(^next_bits);
        hdr_end   = sck_fall && !hdr_done && (hcnt == HCNT_W'(HDR_W - 1));
        word_end  = sck_fall && hdr_done && (wcnt == WCNT_W'(DATA_W - 1));
        partial   = (!hdr_done && hcnt != '0) || (hdr_done && wcnt != '0);
    end

    // Bit counters, header capture and burst poisoning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            hcnt      <= '0;
            wcnt      <= '0;
            hdr_done  <= 1'b0;
            is_read   <= 1'b0;
            burst_bad <= 1'b0;
        end else if (cs_fall) begin
            hcnt      <= '0;
            wcnt      <= '0;
            hdr_done  <= 1'b0;
            burst_bad <= 1'b0;
        end else if (sck_fall) begin
            rx_sh <= next_bits[DATA_W-2:0];
            if (!hdr_done) begin
                if (hdr_end) begin
                    hdr_done  <= 1'b1;
                    is_read   <= hdr[HDR_W-1];
                    burst_bad <= !hdr_ok;
                    hcnt      <= '0;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end else begin
                wcnt <= word_end ? '0 : wcnt + 1'b1;
                if (word_end && !is_read && !word_ok) begin
                    burst_bad <= 1'b1;
                end
            end
        end
    end

    // Read and write address pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else if (hdr_end) begin
            if (hdr[HDR_W-1]) begin
                rd_ptr <= hdr[ADDR_W:1];
            end else if (hdr_ok) begin
                wr_ptr <= hdr[ADDR_W:1];
            end
        end else if (word_end) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (!is_read && word_ok && !burst_bad) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    // Register write strobe and the transmit reload request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            word_ready <= 1'b0;
        end else begin
            wr_en      <= word_end && !is_read && word_ok && !burst_bad;
            word_ready <= hdr_end || word_end;
            if (word_end) begin
                wr_addr <= wr_ptr;
                wr_data <= par_en ? {1'b0, next_bits[DATA_W-2:0]} : next_bits;
            end
        end
    end

    // Sticky flags: a clear pulse drops them, a new error in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (clr_fault) begin
                flags <= '0;
            end
            if ((hdr_end && !hdr_ok) || (word_end && !is_read && !word_ok)) begin
                flags.parity <= 1'b1;
            end
            if (cs_rise && partial) begin
                flags.frame <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rg_tx.sv
// Transmit shifter: status byte during the header, then one register
// word per data slot, shifted MSB first after each serial rising edge.
// Assumes load_req never coincides with sck_rise (edges are apart).
module spi_rg_tx #(
    parameter int DATA_W = 16,
    parameter int HDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              load_req,
    input  logic              par_en,
    input  logic [HDR_W-1:0]  status_byte,
    input  logic [DATA_W-1:0] rd_word,
    output logic              sdo
);
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rd_out;
    logic              pend;
    logic              first;

    // Optionally replace the returned MSB with even parity of the payload.
    always_comb begin
        rd_out = par_en ? {^rd_word[DATA_W-2:0], rd_word[DATA_W-2:0]} : rd_word;
        sdo    = tx_sh[DATA_W-1];
    end

    // Shift register with pending reload at word boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            pend  <= 1'b0;
            first <= 1'b0;
        end else if (cs_fall) begin
            tx_sh <= {status_byte, {(DATA_W - HDR_W){1'b0}}};
            pend  <= 1'b0;
            first <= 1'b1;
        end else begin
            if (sck_rise) begin
                if (pend) begin
                    tx_sh <= rd_out;
                    pend  <= 1'b0;
                end else if (first) begin
                    first <= 1'b0;
                end else begin
                    tx_sh <= tx_sh << 1;
                end
            end
            if (load_req) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rg_target.sv
// Top of the SPI register-access target. Wires edge detection, the
// receive path and the transmit shifter around an external register bank.
// Assumes reg_rd_data follows reg_rd_addr combinationally.
module spi_rg_target
    import spi_rg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              par_en,
    input  logic              clr_fault,
    input  logic [ADDR_W-1:0] status_in,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              fault_n
);
    localparam int HDR_W = ADDR_W + 2;

    logic   cs_fall;
    logic   cs_rise;
    logic   sck_fall;
    logic   sck_rise;
    logic   word_ready;
    fault_t flags;

    spi_rg_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (csn),
        .sclk     (sclk),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_fall (sck_fall),
        .sck_rise (sck_rise)
    );

    spi_rg_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sck_fall   (sck_fall),
        .sdi        (sdi),
        .par_en     (par_en),
        .clr_fault  (clr_fault),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_ptr     (reg_rd_addr),
        .word_ready (word_ready),
        .flags      (flags)
    );

    spi_rg_tx #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .sck_rise    (sck_rise),
        .load_req    (word_ready),
        .par_en      (par_en),
        .status_byte ({status_in, flags.parity, flags.frame}),
        .rd_word     (reg_rd_data),
        .sdo         (sdo)
    );

    // Drive enable and the active-low fault pin.
    always_comb begin
        sdo_oe  = ~csn;
        fault_n = ~(flags.parity | flags.frame);
    end
endmodule

// File: rtl/spi_rg_target_chk.sv
// Protocol checker bound to spi_rg_target.
module spi_rg_target_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn,
    input logic              sclk,
    input logic              sdo,
    input logic              clr_fault,
    input logic              fault_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_rd_addr
);
    // R4: register writes happen only inside a selected frame.
    assert_wr_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !csn);

    // R5: each completed word produces a single-cycle write strobe.
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R1: the read pointer does not move while the target is deselected.
    assert_rdptr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csn && $past(csn)) |-> $stable(reg_rd_addr));

    // R11: a raised fault holds until a clear pulse.
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !clr_fault) |=> !fault_n);

    // R3: inside a frame, SDO changes only after a serial rising edge.
    assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn && $past(!csn) && $past(!csn, 2) && !$stable(sdo))
            |-> ($past(sclk) && !$past(sclk, 2)));
endmodule

bind spi_rg_target spi_rg_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn         (csn),
    .sclk        (sclk),
    .sdo         (sdo),
    .clr_fault   (clr_fault),
    .fault_n     (fault_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_addr (reg_rd_addr)
);

// File: tb/spi_rg_target_test.sv
module spi_rg_target_test;
    localparam int HP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        par_en = 1'b0;
    logic        clr_fault = 1'b0;
    logic [5:0]  status_in = 6'h2D;
    logic        sdo, sdo_oe, reg_wr_en, fault_n;
    logic [5:0]  reg_wr_addr, reg_rd_addr;
    logic [15:0] reg_wr_data, reg_rd_data;

    always #10 clk = ~clk;

    spi_rg_target uut (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .par_en(par_en), .clr_fault(clr_fault),
        .status_in(status_in), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .fault_n(fault_n)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0321) ^ 16'h5A5A;
    endfunction

    // Register bank attached to the block's ports.
    logic [15:0] bank [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bank[i] <= init_val(i);
        end else if (reg_wr_en) begin
            bank[reg_wr_addr] <= reg_wr_data;
        end
    end
    assign reg_rd_data = bank[reg_rd_addr];

    // Behavioural reference model.
    logic [15:0] m_reg [64];
    logic [5:0]  m_rd = 6'd0, m_wr = 6'd0;
    bit          m_perr = 0, m_ferr = 0, pen = 0;
    int          n_chk = 0, n_fail = 0, cyc = 0, quiet = 0;
    logic        csn_d = 1'b1, sclk_d = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog (all) actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    // Quiet-time tracker and per-clock comparison against the model.
    always @(posedge clk) begin
        if (csn != csn_d || sclk != sclk_d || clr_fault) quiet <= 0;
        else quiet <= quiet + 1;
        csn_d  <= csn;
        sclk_d <= sclk;
    end
    always @(posedge clk) begin
        #5;
        if (rst_n && quiet >= 4) begin
            chk(fault_n == !(m_perr | m_ferr), "R11 fault pin per clock", fault_n, !(m_perr | m_ferr));
            chk(sdo_oe == !csn, "R4 output enable per clock", sdo_oe, !csn);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: rise with data, sample SDO, then drive the fall.
    task automatic bit_x(input logic b, output logic got);
        sclk = 1'b1;
        sdi  = b;
        tick(HP);
        got  = sdo;
        sclk = 1'b0;
    endtask

    function automatic logic [7:0] mkh(input bit rw, input logic [5:0] a, input bit good);
        logic p;
        p = ^{rw, a};
        return {rw, a, good ? p : ~p};
    endfunction

    function automatic logic [15:0] mkw(input logic [14:0] p, input bit good);
        return {(^p) ^ !good, p};
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] v);
        return pen ? {^v[14:0], v[14:0]} : v;
    endfunction

    task automatic bank_chk(input string tag);
        int bad = 0;
        for (int i = 0; i < 64; i++) if (bank[i] !== m_reg[i]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic frame(input logic [7:0] hdr, input int hbits, input logic [15:0] dq[$],
                         input int pbits, input string tag);
        logic [7:0]  st_exp, st_got;
        logic [15:0] w_got, w_exp, w;
        logic        got;
        bit          rw, hok, wok, bad;
        st_exp = {status_in, m_perr, m_ferr};
        st_got = '0;
        bad    = 0;
        rw     = hdr[7];
        csn    = 1'b0;
        tick(HP);
        for (int i = 7; i >= 8 - hbits; i--) begin
            bit_x(hdr[i], got);
            st_got[i] = got;
            if (i == 0) begin
                hok = !pen || !(^hdr);
                if (!hok) m_perr = 1;
                if (rw) m_rd = hdr[6:1];
                else if (hok) m_wr = hdr[6:1];
                bad = !hok;
            end
            tick(HP);
        end
        if (hbits < 8) begin
            csn = 1'b1;
            if (hbits > 0) m_ferr = 1;
            tick(2 * HP);
            bank_chk({tag, " bank"});
            return;
        end
        chk(st_got == st_exp, "R2 status byte", st_got, st_exp);
        foreach (dq[k]) begin
            w     = dq[k];
            w_exp = exp_rd(m_reg[m_rd]);
            for (int j = 15; j >= 0; j--) begin
                bit_x(w[j], got);
                w_got[j] = got;
                if (j == 0) begin
                    m_rd = m_rd + 1'b1;
                    if (!rw) begin
                        wok = !pen || !(^w);
                        if (!wok) m_perr = 1;
                        if (wok && !bad) begin
                            m_reg[m_wr] = pen ? {1'b0, w[14:0]} : w;
                            m_wr = m_wr + 1'b1;
                        end else begin
                            bad = 1;
                        end
                    end
                end
                tick(HP);
            end
            chk(w_got == w_exp, tag, w_got, w_exp);
        end
        for (int k = 0; k < pbits; k++) begin
            bit_x(1'b1, got);
            tick(HP);
        end
        csn = 1'b1;
        if (pbits > 0) m_ferr = 1;
        tick(2 * HP);
        bank_chk({tag, " bank"});
    endtask

    task automatic clear_flags();
        clr_fault = 1'b1;
        m_perr = 0;
        m_ferr = 0;
        tick(1);
        clr_fault = 1'b0;
        tick(HP);
        chk(fault_n == 1'b1, "R11 clear pulse", fault_n, 1);
    endtask

    initial begin
        logic [15:0] q[$];
        for (int i = 0; i < 64; i++) m_reg[i] = init_val(i);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk(fault_n == 1'b1, "R11 reset fault_n", fault_n, 1);
        chk(sdo_oe == 1'b0, "R4 reset sdo_oe", sdo_oe, 0);
        chk(reg_wr_en == 1'b0, "R5 reset write strobe", reg_wr_en, 0);

        // Parity off: write burst with a wrong header parity bit.
        q = '{16'hF00F, 16'h8001, 16'h1234};
        frame(mkh(0, 6'd5, 0), 8, q, 0, "R5 R6 R12 write burst, parity off");
        chk(fault_n == 1'b1, "R12 no parity flag", fault_n, 1);

        q = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
        frame(mkh(1, 6'd4, 1), 8, q, 0, "R1 R3 read burst");
        status_in = 6'h12;
        q = '{16'hAAAA, 16'h5555};
        frame(mkh(0, 6'd10, 1), 8, q, 0, "R5 write watches read pointer");
        q = '{16'h0, 16'h0, 16'h0, 16'h0};
        frame(mkh(1, 6'd62, 1), 8, q, 0, "R1 read wraps at 63");

        // Parity on.
        pen = 1; par_en = 1'b1;
        q = '{16'h0, 16'h0, 16'h0};
        frame(mkh(1, 6'd5, 1), 8, q, 0, "R9 parity inserted in read data");
        q = '{mkw(15'h7123, 1), mkw(15'h0456, 0), mkw(15'h0789, 1)};
        frame(mkh(0, 6'd20, 1), 8, q, 0, "R7 R6 bad word poisons burst");
        chk(fault_n == 1'b0, "R7 parity flag on fault pin", fault_n, 0);
        q = '{};
        frame(mkh(1, 6'd30, 1), 8, q, 0, "R10 header-only frame");
        chk(m_ferr == 0 && fault_n == 1'b0, "R10 exact header no frame flag", fault_n, 0);
        clear_flags();

        q = '{16'h0, 16'h0};
        frame(mkh(1, 6'd40, 0), 8, q, 0, "R8 read despite header parity error");
        chk(fault_n == 1'b0, "R8 header error flagged", fault_n, 0);
        clear_flags();
        q = '{mkw(15'h1111, 1), mkw(15'h2222, 1)};
        frame(mkh(0, 6'd41, 0), 8, q, 0, "R8 write dropped on header error");
        clear_flags();

        q = '{mkw(15'h3333, 1)};
        frame(mkh(0, 6'd50, 1), 8, q, 5, "R10 partial word dropped");
        chk(fault_n == 1'b0, "R10 frame flag on fault pin", fault_n, 0);
        clear_flags();
        q = '{};
        frame(mkh(1, 6'd12, 1), 3, q, 0, "R10 partial header");
        chk(fault_n == 1'b0, "R10 partial header flagged", fault_n, 0);
        clear_flags();

        // Select high: serial activity must be ignored.
        for (int k = 0; k < 10; k++) begin
            sclk = 1'b1; sdi = k[0];
            tick(HP);
            sclk = 1'b0;
            tick(HP);
        end
        chk(sdo_oe == 1'b0, "R4 idle sdo_oe", sdo_oe, 0);
        bank_chk("R4 idle bank unchanged");
        q = '{mkw(15'h4444, 1)};
        frame(mkh(0, 6'd51, 1), 8, q, 0, "R4 read pointer unchanged after idle noise");

        // Parity off again: odd-parity data is stored as received.
        pen = 0; par_en = 1'b0;
        q = '{16'h0001, 16'h8000};
        frame(mkh(0, 6'd60, 1), 8, q, 0, "R12 R6 parity off stores raw words");
        chk(fault_n == 1'b1, "R12 fault pin stays high", fault_n, 1);

        tick(10);
        summary();
        $finish;
    end
endmodule